// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address to a 28-bit physical address by reading a two-level page table held in memory. It is used after a miss in the translation buffer. A walk request carries the virtual address and the page-table base. The walker reads one entry from the first-level table. If that entry is valid, it reads one entry from the second-level table. It then returns the 15-bit frame number with the five permission flags, or it raises a fault that says which level was not present.

Pages are 8 KB, so the low 13 address bits pass through without translation and the 19-bit page number is translated. The page number is split unevenly between the two levels. The upper 8 bits select one of 256 entries in a 1 KB first-level table. The lower 11 bits select one of 2048 entries in an 8 KB second-level table. Each entry is 4 bytes. Only one walk is in flight at a time. Memory reads use a valid/ready request channel and a response strobe, and the response may arrive any number of cycles after the request is taken.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and after reset is released, `req_ready_o` is 1, and `mem_req_valid_o`, `done_o` and `fault_o` are 0.
- R2: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1. From the next cycle, `req_ready_o` stays 0 until the cycle in which `done_o` or `fault_o` pulses, and it is 1 again in that cycle.
- R3: In the cycle after acceptance, the walker issues a read at `ptbr_i + va[31:24]*4`, taken modulo 2^28, using the values latched at acceptance. The address stays stable while `mem_req_ready_i` is 0.
- R4: Entry layout: bits 14:0 hold the frame number; bit 15 is valid, bit 16 readable, bit 17 writeable, bit 18 executable, bit 19 kernel-only; bits 31:20 are ignored.
- R5: After a valid first-level entry, the second read goes to `{frame, 13'b0} + va[23:13]*4`.
- R6: When the second-level entry is valid, `done_o` pulses for one cycle, in the cycle after its response. In that cycle `done_pfn_o` holds bits 14:0 of the entry, and `done_flags_o` holds bits 19:15 of the entry, with bit 0 = valid up to bit 4 = kernel-only.
- R7: A first-level entry with its valid bit clear makes `fault_o` pulse with `fault_level_o`=0, in the cycle after the response. No second read is issued.
- R8: A second-level entry with its valid bit clear makes `fault_o` pulse with `fault_level_o`=1, in the cycle after the response.
- R9: Any number of cycles of request back-pressure or response latency is tolerated. Nothing completes while a response is outstanding.
- R10: Each walk ends with exactly one one-cycle pulse, on either `done_o` or `fault_o`, never on both.
- R11: The flags and upper bits of a valid first-level entry have no effect on the result. Only its frame number is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Walk request |
| req_ready_o | output | 1 | Walker idle, request can be taken |
| req_va_i | input | 32 | Virtual address to translate |
| ptbr_i | input | 28 | Physical base of the first-level table |
| mem_req_valid_o | output | 1 | Memory read request |
| mem_req_ready_i | input | 1 | Memory takes the read |
| mem_addr_o | output | 28 | Read byte address |
| mem_rsp_valid_i | input | 1 | Read data strobe |
| mem_rsp_data_i | input | 32 | Read data (one table entry) |
| done_o | output | 1 | Translation completed (one cycle) |
| done_pfn_o | output | 15 | Translated frame number |
| done_flags_o | output | 5 | {kernel, exec, write, read, valid} |
| fault_o | output | 1 | Not-present fault (one cycle) |
| fault_level_o | output | 1 | 0: first level, 1: second level |

## Verification
The checks assume that memory returns exactly one response per accepted read. They also assume that no response strobe arrives while no read is outstanding. The bench's memory model follows this rule: it raises the response strobe only after it has seen its own request taken, and it waits a random 0 to 4 cycles first. It also holds off `mem_req_ready_i` for a random 0 to 3 cycles. Request fields are scrambled after acceptance, so the bench can confirm that the walker uses the latched values.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int unsigned FLAG_N = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT
  } walk_st_e;
endpackage

// File: rtl/pt_walker_addr.sv
module pt_walker_addr #(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 28,
  parameter int unsigned PAGE_BITS = 13,
  parameter int unsigned L1_BITS   = 8,
  localparam int unsigned VPN_W    = VA_W - PAGE_BITS,
  localparam int unsigned L2_BITS  = VPN_W - L1_BITS,
  localparam int unsigned PFN_W    = PA_W - PAGE_BITS
) (
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [PFN_W-1:0] l1_pfn_i,
  output logic [PA_W-1:0]  l1_addr_o,
  output logic [PA_W-1:0]  l2_addr_o
);
  logic [L1_BITS-1:0] l1_idx;
  logic [L2_BITS-1:0] l2_idx;

  assign l1_idx = vpn_i[VPN_W-1 -: L1_BITS];
  assign l2_idx = vpn_i[L2_BITS-1:0];

  // entries are 4 bytes: index scaled by 4
  assign l1_addr_o = base_i + PA_W'({l1_idx, 2'b00});
  assign l2_addr_o = {l1_pfn_i, {PAGE_BITS{1'b0}}} + PA_W'({l2_idx, 2'b00});
endmodule

// File: rtl/pt_walker_pte.sv
module pt_walker_pte #(
  parameter int unsigned PTE_W  = 32,
  parameter int unsigned PFN_W  = 15,
  parameter int unsigned FLAG_N = 5
) (
  input  logic [PTE_W-1:0]  pte_i,
  output logic [PFN_W-1:0]  pfn_o,
  output logic [FLAG_N-1:0] flags_o,
  output logic              valid_o
);
  logic unused_hi;

  assign pfn_o = pte_i[PFN_W-1:0];

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    assign flags_o[g] = pte_i[PFN_W+g];
  end

  assign valid_o   = flags_o[0];
  assign unused_hi = ^pte_i[PTE_W-1:PFN_W+FLAG_N];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 28,
  parameter int unsigned PAGE_BITS = 13,
  parameter int unsigned L1_BITS   = 8,
  parameter int unsigned PTE_W     = 32,
  localparam int unsigned VPN_W    = VA_W - PAGE_BITS,
  localparam int unsigned PFN_W    = PA_W - PAGE_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic [PA_W-1:0]   ptbr_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [PA_W-1:0]   mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [PTE_W-1:0]  mem_rsp_data_i,
  output logic              done_o,
  output logic [PFN_W-1:0]  done_pfn_o,
  output logic [FLAG_N-1:0] done_flags_o,
  output logic              fault_o,
  output logic              fault_level_o
);
  walk_st_e          st_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [PA_W-1:0]   base_q;
  logic [PFN_W-1:0]  l1_pfn_q;
  logic [PA_W-1:0]   l1_addr, l2_addr;
  logic [PFN_W-1:0]  pte_pfn;
  logic [FLAG_N-1:0] pte_flags;
  logic              pte_valid;
  logic              unused_off;

  assign unused_off = ^req_va_i[PAGE_BITS-1:0];

  pt_walker_addr #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .L1_BITS(L1_BITS)
  ) u_addr (
    .vpn_i    (vpn_q),
    .base_i   (base_q),
    .l1_pfn_i (l1_pfn_q),
    .l1_addr_o(l1_addr),
    .l2_addr_o(l2_addr)
  );

  pt_walker_pte #(
    .PTE_W(PTE_W), .PFN_W(PFN_W), .FLAG_N(FLAG_N)
  ) u_pte (
    .pte_i  (mem_rsp_data_i),
    .pfn_o  (pte_pfn),
    .flags_o(pte_flags),
    .valid_o(pte_valid)
  );

  assign req_ready_o     = (st_q == ST_IDLE);
  assign mem_req_valid_o = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ);
  assign mem_addr_o      = (st_q == ST_L2_REQ) ? l2_addr : l1_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      vpn_q         <= '0;
      base_q        <= '0;
      l1_pfn_q      <= '0;
      done_o        <= 1'b0;
      done_pfn_o    <= '0;
      done_flags_o  <= '0;
      fault_o       <= 1'b0;
      fault_level_o <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          vpn_q  <= req_va_i[VA_W-1:PAGE_BITS];
          base_q <= ptbr_i;
          st_q   <= ST_L1_REQ;
        end
        ST_L1_REQ: if (mem_req_ready_i) st_q <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid_i) begin
          if (!pte_valid) begin
            fault_o       <= 1'b1;
            fault_level_o <= 1'b0;
            st_q          <= ST_IDLE;
          end else begin
            l1_pfn_q <= pte_pfn;
            st_q     <= ST_L2_REQ;
          end
        end
        ST_L2_REQ: if (mem_req_ready_i) st_q <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rsp_valid_i) begin
          if (!pte_valid) begin
            fault_o       <= 1'b1;
            fault_level_o <= 1'b1;
          end else begin
            done_o       <= 1'b1;
            done_pfn_o   <= pte_pfn;
            done_flags_o <= pte_flags;
          end
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned PA_W    = 28,
  parameter int unsigned L1_BITS = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic [L1_BITS-1:0] l1_idx_i,
  input logic [PA_W-1:0]    ptbr_i,
  input logic               mem_req_valid_o,
  input logic               mem_req_ready_i,
  input logic [PA_W-1:0]    mem_addr_o,
  input logic               mem_rsp_valid_i,
  input logic               done_o,
  input logic               fault_o,
  input logic               fault_level_o
);
  p_busy_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_no_ready_while_reading_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);

  p_first_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=>
      (mem_req_valid_o && mem_addr_o == $past(ptbr_i) + PA_W'({$past(l1_idx_i), 2'b00})));

  p_addr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o)));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_l1_fault_no_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !fault_level_o) |-> (!mem_req_valid_o && req_ready_o));

  p_end_follows_rsp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |-> $past(mem_rsp_valid_i));

  p_one_outcome_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .L1_BITS(L1_BITS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .l1_idx_i       (req_va_i[VA_W-1 -: L1_BITS]),
  .ptbr_i         (ptbr_i),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_addr_o     (mem_addr_o),
  .mem_rsp_valid_i(mem_rsp_valid_i),
  .done_o         (done_o),
  .fault_o        (fault_o),
  .fault_level_o  (fault_level_o)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [27:0] ptbr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [27:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done;
  logic [14:0] done_pfn;
  logic [4:0]  done_flags;
  logic        fault;
  logic        fault_level;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_va_i(req_va), .ptbr_i(ptbr),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_addr_o(mem_addr), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i(mem_rsp_data),
    .done_o(done), .done_pfn_o(done_pfn), .done_flags_o(done_flags),
    .fault_o(fault), .fault_level_o(fault_level)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [27:0] exp_l1(input logic [31:0] va, input logic [27:0] base);
    return base + {18'b0, va[31:24], 2'b00};
  endfunction

  function automatic logic [27:0] exp_l2(input logic [31:0] va, input logic [31:0] l1);
    return {l1[14:0], 13'b0} + {15'b0, va[23:13], 2'b00};
  endfunction

  // one memory read: handshake with stalls, then response after latency
  task automatic mem_phase(input logic [27:0] ea, input logic [31:0] data, input string tag);
    int stall, lat;
    chk({tag, " read issued"}, 32'(mem_req_valid), 32'd1);
    chk({tag, " read address"}, 32'(mem_addr), 32'(ea));
    stall = int'($urandom % 4);
    for (int k = 0; k < stall; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R9 address held under stall", 32'(mem_addr), 32'(ea));
    end
    mem_req_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R9 request dropped after take", 32'(mem_req_valid), 32'd0);
    lat = int'($urandom % 5);
    for (int k = 0; k < lat; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R9 no outcome while waiting", 32'({done, fault}), 32'd0);
      chk("R2 busy while waiting", 32'(req_ready), 32'd0);
    end
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = data;
    @(posedge clk); @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = $urandom;
  endtask

  task automatic walk(input logic [31:0] va, input logic [27:0] base,
                      input logic [31:0] l1, input logic [31:0] l2, input string note);
    req_valid = 1'b1;
    req_va    = va;
    ptbr      = base;
    chk({"R2 ready when idle ", note}, 32'(req_ready), 32'd1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    req_va    = $urandom;
    ptbr      = 28'($urandom);
    chk({"R2 busy after accept ", note}, 32'(req_ready), 32'd0);
    mem_phase(exp_l1(va, base), l1, "R3");
    if (!l1[15]) begin
      chk({"R7 fault pulse ", note}, 32'(fault), 32'd1);
      chk({"R7 fault level ", note}, 32'(fault_level), 32'd0);
      chk({"R10 no done on fault ", note}, 32'(done), 32'd0);
      chk({"R2 ready with outcome ", note}, 32'(req_ready), 32'd1);
      chk({"R7 no second read ", note}, 32'(mem_req_valid), 32'd0);
      @(posedge clk); @(negedge clk);
      chk({"R10 fault one cycle ", note}, 32'(fault), 32'd0);
      chk({"R7 still no read ", note}, 32'(mem_req_valid), 32'd0);
      return;
    end
    mem_phase(exp_l2(va, l1), l2, "R5");
    if (l2[15]) begin
      chk({"R6 done pulse ", note}, 32'(done), 32'd1);
      chk({"R6 frame ", note}, 32'(done_pfn), 32'(l2[14:0]));
      chk({"R4 flags ", note}, 32'(done_flags), 32'(l2[19:15]));
      chk({"R10 no fault on done ", note}, 32'(fault), 32'd0);
    end else begin
      chk({"R8 fault pulse ", note}, 32'(fault), 32'd1);
      chk({"R8 fault level ", note}, 32'(fault_level), 32'd1);
      chk({"R10 no done on fault ", note}, 32'(done), 32'd0);
    end
    chk({"R2 ready with outcome ", note}, 32'(req_ready), 32'd1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    chk("R1 ready in reset", 32'(req_ready), 32'd1);
    chk("R1 no read in reset", 32'(mem_req_valid), 32'd0);
    chk("R1 no outcome in reset", 32'({done, fault}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(req_ready), 32'd1);
    chk("R1 no outcome after reset", 32'({done, fault}), 32'd0);

    walk(32'h0000_0000, 28'h000_1000, 32'h0000_8003, 32'h000F_8123, "basic");
    walk(32'h1234_5678, 28'h010_0000, 32'h0000_0007, 32'h0000_0000, "L1 invalid");
    walk(32'hABCD_E000, 28'h020_0000, 32'h0000_8010, 32'h0007_7FFF, "L2 invalid");
    walk(32'hFFFF_FFFF, 28'hFFF_FFFC, 32'h0000_FFFF, 32'h0009_FFFF, "wrap and max");
    walk(32'h8000_2000, 28'h000_0400, 32'hFFFF_8042, 32'h0001_8001, "R11 L1 flags ignored");
    walk(32'h8000_2000, 28'h000_0400, 32'h0000_8042, 32'h0001_8001, "R11 reference");
    walk(32'h00FF_E000, 28'h000_0000, 32'h0007_8100, 32'hFFF0_8055, "R4 high bits ignored");

    for (int i = 0; i < 300; i++) begin
      logic [31:0] l1, l2;
      l1 = $urandom;
      l2 = $urandom;
      l1[15] = ($urandom % 8) != 0;
      l2[15] = ($urandom % 8) != 0;
      walk($urandom, 28'($urandom), l1, l2, "random");
      if ($urandom % 2 == 1) begin
        @(posedge clk); @(negedge clk);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule